// File: doc/BRIEF.md
# Shift-XOR Pseudorandom Word Generator

This block keeps an N-bit state word and, on each cycle in which its advance input is high, replaces that word with a new one. The new word comes from three shift-and-XOR passes applied one after another: left by A, then right by B, then left by C. Each pass works on the result of the pass before it. Left shifts drop any bits moved past the top bit. The right shift fills with zeros. With the default triple (7, 5, 3) and N = 8, the state visits every non-zero value once per 255 advances. With N = 16 and the triple (13, 9, 7), it visits every non-zero value once per 65535 advances. Because the all-zero state would never leave itself, zero is kept out of the state at every point of entry: a zero seed is replaced by 1.

A synchronous load input places a seed in the state. A compile-time output shaper picks how the state is presented:
- the whole word;
- only its low K bits, where zero then occurs a little less often than the other values;
- the word minus one, which covers 0 to 2^N-2.

The output is registered. A small controller tracks whether that output holds a newly advanced value. It has three named states:
- GS_IDLE: the output is unchanged since the last edge.
- GS_FRESH: the last edge advanced the state.
- GS_SEEDED: the last edge loaded a seed.

The controller's transitions are the same from every state:
- load high goes to GS_SEEDED;
- otherwise advance high goes to GS_FRESH;
- otherwise it goes to GS_IDLE.

The valid flag is high only in GS_FRESH.

Top module: `xorshift_gen`

## Requirements
- R1: After reset the state equals the SEED parameter (default 1), the output is the shaped seed and the valid flag is low, with the controller in GS_IDLE.
- R2: An advance applies s ^= s << A, then s ^= s >> B, then s ^= s << C. Left shifts truncate to N bits and the right shift is logical. From state 0x01 the 8-bit default gives 0xAD, and from 0xAD it gives 0x4C.
- R3: With N = 8 and (7, 5, 3), the full-width output first returns to its starting value after exactly 255 advances and is never zero.
- R4: A load with a non-zero seed makes the state and the full-width output equal that seed on the next cycle, with the valid flag low (GS_SEEDED).
- R5: A load with an all-zero seed puts 1 into the state.
- R6: When load and advance are both high in one cycle, the load wins and the advance has no effect.
- R7: In a cycle with neither load nor advance, the state and output hold and the valid flag is low on the next cycle (GS_IDLE).
- R8: The output changes and the valid flag is high in the cycle after an advance is sampled (GS_FRESH).
- R9: In low-bits mode (K = 6, N = 8) the output is the state's low 6 bits, zero-extended. Over one period each non-zero 6-bit value appears 4 times and zero appears 3 times.
- R10: In minus-one mode the output is the state minus one. Over one 8-bit period it takes each value 0 to 254 exactly once and never takes 255.
- R11: With N = 16 and (13, 9, 7), the output first returns to its starting value after exactly 65535 advances and is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance the state by one step |
| load_i | input | 1 | Load seed_i into the state (zero becomes 1) |
| seed_i | input | WIDTH | Seed word |
| rnd_o | output | WIDTH | Shaped, registered output word |
| vld_o | output | 1 | High while rnd_o holds a freshly advanced value |

## Verification
The assertions assume that load_i, adv_i and seed_i are stable and known at each rising edge. The non-zero state check also assumes that SEED is non-zero and that the shift triple gives the full period. The bench therefore changes inputs only on the falling edge and never drives X. It uses only the two stated triples and the default seed. The load and advance inputs are exercised in every combination, including both high together and a zero seed.

// File: rtl/xorshift_pkg.sv
package xorshift_pkg;

    // Output presentation of the state word
    typedef enum logic [1:0] {
        SHAPE_FULL = 2'd0,
        SHAPE_LOW  = 2'd1,
        SHAPE_DEC  = 2'd2
    } shape_e;

    // Controller states: what the last edge did to the output
    typedef enum logic [1:0] {
        GS_IDLE   = 2'd0,
        GS_FRESH  = 2'd1,
        GS_SEEDED = 2'd2
    } gen_state_e;

endpackage

// File: rtl/xs_shift_xor_step.sv
module xs_shift_xor_step #(
    parameter int WIDTH = 8,
    parameter int AMT   = 1,
    parameter bit LEFT  = 1'b1
) (
    input  logic [WIDTH-1:0] x_i,
    output logic [WIDTH-1:0] y_o
);

    generate
        if (LEFT) begin : g_left
            // bits pushed past the top are discarded by the width
            assign y_o = x_i ^ (x_i << AMT);
        end else begin : g_right
            // logical shift, zero fill
            assign y_o = x_i ^ (x_i >> AMT);
        end
    endgenerate

endmodule

// File: rtl/xs_next_state.sv
module xs_next_state #(
    parameter int WIDTH = 8,
    parameter int SH_A  = 7,
    parameter int SH_B  = 5,
    parameter int SH_C  = 3
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);

    logic [WIDTH-1:0] pass1;
    logic [WIDTH-1:0] pass2;

    xs_shift_xor_step #(.WIDTH(WIDTH), .AMT(SH_A), .LEFT(1'b1)) u_pass_a (
        .x_i (cur_i),
        .y_o (pass1)
    );

    xs_shift_xor_step #(.WIDTH(WIDTH), .AMT(SH_B), .LEFT(1'b0)) u_pass_b (
        .x_i (pass1),
        .y_o (pass2)
    );

    xs_shift_xor_step #(.WIDTH(WIDTH), .AMT(SH_C), .LEFT(1'b1)) u_pass_c (
        .x_i (pass2),
        .y_o (nxt_o)
    );

endmodule

// File: rtl/xs_seed_guard.sv
module xs_seed_guard #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] safe_o
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb begin
        if (seed_i == '0) begin
            safe_o = ONE;
        end else begin
            safe_o = seed_i;
        end
    end

endmodule

// File: rtl/xs_out_shape.sv
module xs_out_shape #(
    parameter int                   WIDTH    = 8,
    parameter xorshift_pkg::shape_e MODE     = xorshift_pkg::SHAPE_FULL,
    parameter int                   LOW_BITS = 6
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] word_o
);

    localparam int               KEEP = (LOW_BITS >= WIDTH) ? WIDTH : LOW_BITS;
    localparam logic [WIDTH-1:0] MASK = {WIDTH{1'b1}} >> (WIDTH - KEEP);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    generate
        if (MODE == xorshift_pkg::SHAPE_LOW) begin : g_low
            assign word_o = state_i & MASK;
        end else if (MODE == xorshift_pkg::SHAPE_DEC) begin : g_dec
            assign word_o = state_i - ONE;
        end else begin : g_full
            assign word_o = state_i;
        end
    endgenerate

endmodule

// File: rtl/xorshift_gen.sv
module xorshift_gen #(
    parameter int                   WIDTH    = 8,
    parameter int                   SH_A     = 7,
    parameter int                   SH_B     = 5,
    parameter int                   SH_C     = 3,
    parameter logic [WIDTH-1:0]     SEED     = 1,
    parameter xorshift_pkg::shape_e MODE     = xorshift_pkg::SHAPE_FULL,
    parameter int                   LOW_BITS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] rnd_o,
    output logic             vld_o
);

    import xorshift_pkg::*;

    gen_state_e       cur_q;
    gen_state_e       cur_d;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic [WIDTH-1:0] stepped;
    logic [WIDTH-1:0] seed_safe;
    logic [WIDTH-1:0] shaped_d;
    logic [WIDTH-1:0] shaped_rst;
    logic [WIDTH-1:0] rnd_q;

    xs_next_state #(.WIDTH(WIDTH), .SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C)) u_next (
        .cur_i (state_q),
        .nxt_o (stepped)
    );

    xs_seed_guard #(.WIDTH(WIDTH)) u_guard (
        .seed_i (seed_i),
        .safe_o (seed_safe)
    );

    // next-state selection: load has priority over advance
    always_comb begin
        if (load_i) begin
            state_d = seed_safe;
        end else if (adv_i) begin
            state_d = stepped;
        end else begin
            state_d = state_q;
        end
    end

    xs_out_shape #(.WIDTH(WIDTH), .MODE(MODE), .LOW_BITS(LOW_BITS)) u_shape (
        .state_i (state_d),
        .word_o  (shaped_d)
    );

    xs_out_shape #(.WIDTH(WIDTH), .MODE(MODE), .LOW_BITS(LOW_BITS)) u_shape_rst (
        .state_i (SEED),
        .word_o  (shaped_rst)
    );

    // controller transitions
    always_comb begin
        cur_d = cur_q;
        unique case (cur_q)
            GS_IDLE, GS_FRESH, GS_SEEDED: begin
                if (load_i) begin
                    cur_d = GS_SEEDED;
                end else if (adv_i) begin
                    cur_d = GS_FRESH;
                end else begin
                    cur_d = GS_IDLE;
                end
            end
            default: cur_d = GS_IDLE;
        endcase
    end

    // controller and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= GS_IDLE;
            state_q <= SEED;
            rnd_q   <= shaped_rst;
        end else begin
            cur_q   <= cur_d;
            state_q <= state_d;
            rnd_q   <= shaped_d;
        end
    end

    // controller outputs
    always_comb begin
        vld_o = 1'b0;
        unique case (cur_q)
            GS_FRESH:  vld_o = 1'b1;
            GS_IDLE:   vld_o = 1'b0;
            GS_SEEDED: vld_o = 1'b0;
            default:   vld_o = 1'b0;
        endcase
    end

    assign rnd_o = rnd_q;

endmodule

// File: rtl/xorshift_gen_chk.sv
module xorshift_gen_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv_i,
    input logic             load_i,
    input logic [WIDTH-1:0] seed_i,
    input logic [WIDTH-1:0] state_q,
    input logic             vld_o
);

    // R3
    state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R4
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> (state_q == $past(seed_i)));

    // R5
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> (state_q == {{(WIDTH-1){1'b0}}, 1'b1}));

    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !vld_o);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> ($stable(state_q) && !vld_o));

    // R8
    fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> vld_o);

    // R2
    moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (state_q != $past(state_q)));

endmodule

bind xorshift_gen xorshift_gen_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv_i),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .state_q (state_q),
    .vld_o   (vld_o)
);

// File: tb/xorshift_gen_tb_top.sv
module xorshift_gen_tb_top;

    logic        clk;
    logic        rst_n;
    logic        adv;
    logic        load;
    logic [7:0]  seed8;
    logic [15:0] seed16;
    logic [7:0]  rnd_full;
    logic [7:0]  rnd_low;
    logic [7:0]  rnd_dec;
    logic [15:0] rnd_w16;
    logic        vld_full;
    logic        vld_low;
    logic        vld_dec;
    logic        vld_w16;

    int errors = 0;
    int checks = 0;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    xorshift_gen dut_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .load_i(load),
        .seed_i(seed8), .rnd_o(rnd_full), .vld_o(vld_full)
    );

    xorshift_gen #(.MODE(xorshift_pkg::SHAPE_LOW), .LOW_BITS(6)) dut_low (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .load_i(load),
        .seed_i(seed8), .rnd_o(rnd_low), .vld_o(vld_low)
    );

    xorshift_gen #(.MODE(xorshift_pkg::SHAPE_DEC)) dut_dec (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .load_i(load),
        .seed_i(seed8), .rnd_o(rnd_dec), .vld_o(vld_dec)
    );

    xorshift_gen #(.WIDTH(16), .SH_A(13), .SH_B(9), .SH_C(7), .SEED(16'd1)) dut_w16 (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .load_i(load),
        .seed_i(seed16), .rnd_o(rnd_w16), .vld_o(vld_w16)
    );

    function automatic logic [15:0] model16(input logic [15:0] s);
        logic [15:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 9);
        t = t ^ (t << 7);
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic ld, input logic ad, input logic [7:0] sd);
        load  = ld;
        adv   = ad;
        seed8 = sd;
        @(posedge clk);
        @(negedge clk);
    endtask

    // {load, adv, seed, expected rnd, expected valid}
    localparam logic [18:0] VEC [0:7] = '{
        {1'b1, 1'b0, 8'h01, 8'h01, 1'b0},  // R4 load 1
        {1'b0, 1'b1, 8'h00, 8'hAD, 1'b1},  // R2 R8
        {1'b0, 1'b1, 8'h00, 8'h4C, 1'b1},  // R2
        {1'b0, 1'b0, 8'h00, 8'h4C, 1'b0},  // R7 hold
        {1'b1, 1'b1, 8'h00, 8'h01, 1'b0},  // R5 R6 zero seed, load wins
        {1'b0, 1'b1, 8'h00, 8'hAD, 1'b1},  // R8
        {1'b1, 1'b1, 8'hAD, 8'hAD, 1'b0},  // R6 load wins
        {1'b0, 1'b1, 8'h00, 8'h4C, 1'b1}   // R2
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int low_cnt [0:63];
        int dec_seen [0:255];
        int first8;
        int first16;
        int zero8;
        int zero16;
        int mism16;
        int novld;
        logic [15:0] m16;

        rst_n  = 1'b0;
        adv    = 1'b0;
        load   = 1'b0;
        seed8  = 8'h00;
        seed16 = 16'h0000;
        repeat (3) @(negedge clk);

        // R1 reset state
        check(rnd_full == 8'h01, "R1 full", rnd_full, 1);
        check(vld_full == 1'b0, "R1 valid", vld_full, 0);
        check(rnd_dec == 8'h00, "R1 dec", rnd_dec, 0);
        check(rnd_w16 == 16'h0001, "R1 w16", rnd_w16, 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            tick(VEC[i][18], VEC[i][17], VEC[i][16:9]);
            check(rnd_full == VEC[i][8:1], $sformatf("R2/R4-R8 vec%0d rnd", i),
                  rnd_full, VEC[i][8:1]);
            check(vld_full == VEC[i][0], $sformatf("R6/R7/R8 vec%0d valid", i),
                  vld_full, VEC[i][0]);
        end

        // R9/R10 shaped outputs follow the seed after a load
        seed16 = 16'h0001;
        tick(1'b1, 1'b0, 8'h01);
        check(rnd_low == 8'h01, "R9 after load", rnd_low, 1);
        check(rnd_dec == 8'h00, "R10 after load", rnd_dec, 0);

        for (int v = 0; v < 64; v++) low_cnt[v] = 0;
        for (int v = 0; v < 256; v++) dec_seen[v] = 0;
        first8  = 0;
        first16 = 0;
        zero8   = 0;
        zero16  = 0;
        mism16  = 0;
        novld   = 0;
        m16     = 16'h0001;

        for (int n = 1; n <= 65535; n++) begin
            tick(1'b0, 1'b1, 8'h00);
            m16 = model16(m16);
            if (rnd_w16 != m16) mism16++;
            if (rnd_full == 8'h00) zero8++;
            if (rnd_w16 == 16'h0000) zero16++;
            if (!vld_full || !vld_w16) novld++;
            if (first8 == 0 && rnd_full == 8'h01) first8 = n;
            if (first16 == 0 && rnd_w16 == 16'h0001) first16 = n;
            if (n <= 255) begin
                if (rnd_low > 8'd63) low_cnt[0] += 1000;
                else low_cnt[rnd_low[5:0]]++;
                dec_seen[rnd_dec]++;
            end
        end

        check(first8 == 255, "R3 period 8-bit", first8, 255);
        check(zero8 == 0, "R3 zero outputs", zero8, 0);
        check(first16 == 65535, "R11 period 16-bit", first16, 65535);
        check(zero16 == 0, "R11 zero outputs", zero16, 0);
        check(mism16 == 0, "R11 step mismatches", mism16, 0);
        check(novld == 0, "R8 valid drops during run", novld, 0);
        check(low_cnt[0] == 3, "R9 zero count", low_cnt[0], 3);
        begin
            int bad;
            bad = 0;
            for (int v = 1; v < 64; v++) if (low_cnt[v] != 4) bad++;
            check(bad == 0, "R9 non-zero counts", bad, 0);
        end
        begin
            int bad;
            bad = 0;
            for (int v = 0; v < 255; v++) if (dec_seen[v] != 1) bad++;
            check(bad == 0, "R10 each value once", bad, 0);
            check(dec_seen[255] == 0, "R10 no 255", dec_seen[255], 0);
        end

        // R7 hold after the long run
        tick(1'b0, 1'b0, 8'h00);
        check(rnd_full == 8'h01, "R7 hold value", rnd_full, 1);
        check(vld_full == 1'b0, "R7 valid low", vld_full, 0);
        check(rnd_w16 == 16'h0001, "R7 hold w16", rnd_w16, 1);

        // R5 zero seed on 16-bit instance
        seed16 = 16'h0000;
        tick(1'b1, 1'b0, 8'h00);
        check(rnd_w16 == 16'h0001, "R5 w16 zero seed", rnd_w16, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule